// File: doc/BRIEF.md
# Debug-port RAM monitor read sequencer

This block runs whole memory-read transactions against a target whose debug trace port is in RAM-monitor mode. The port is four data pins wide. A port clock, a sync strobe, a mode pin and a target reset pin go with it. A host hands over a 32-bit address and an access size through a valid/ready request channel. The block returns the word it read through a valid/ready response channel.

After its own reset the block first brings the target out of reset. It holds the target reset low while it clocks ten zero nibbles, then releases it and clocks ten more. Only then does it take requests. Each read is framed in the same way. Sync goes low, then a zero lead-in nibble, a command nibble and eight address nibbles are sent. The data pins then turn around and the block polls for the ready status. It then collects two nibbles per byte of the access and reorders them into the response word. The port clock rate is set by a half-period divider input in system clocks.

Top module: `dbgport_rdseq`

## Requirements
- R1: `port_mode` is high at every port clock rising edge, from reset onward.
- R2: After reset, `req_ready` stays low while 20 zero nibbles are clocked out. During all 20, `port_doe` and `port_sync` are high. `port_rst_n` is low for the first ten and high for the last ten.
- R3: Each nibble transfer is one port clock pulse. The clock is high for exactly `half_div` system clocks, where a value of 0 acts as 1. It is low for at least that long before it rises, and each transfer ends with the clock low.
- R4: A read sends a lead-in nibble 4'h0 and then the command nibble {2'b10, size}, where size is 2'b00 for byte, 2'b01 for word and 2'b10 for long word. The reserved size 2'b11 is sent and handled as long word. Sync is low at every rising edge while these nibbles go out.
- R5: After the command nibble, the 32-bit address goes out as eight nibbles, bits 3:0 first and bits 31:28 last, with `port_doe` high.
- R6: After the address, `port_doe` is low and input nibbles are sampled at each rising edge, through a two-flop synchronizer, until one equals 4'b0001. Sync stays low during this polling.
- R7: After the ready status the block reads exactly 2, 4 or 8 data nibbles for byte, word or long word. Sync is high at the rising edge of the first data nibble and low at all later ones.
- R8: Within each byte the first nibble received is bits 3:0. Bytes arrive least-significant first. Bits above the access size are zero in `rsp_data`.
- R9: `rsp_valid` and `rsp_data` hold until `rsp_ready` is taken. `req_ready` is low from request acceptance until the response is accepted, and high again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | 16 | Port clock half-period in system clocks (0 acts as 1) |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 32 | Read address |
| req_size | input | 2 | Access size: 00 byte, 01 word, 10 long word, 11 as long word |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Host takes the read word |
| rsp_data | output | 32 | Assembled read word, zero-extended |
| port_clk | output | 1 | Debug port clock |
| port_dout | output | 4 | Data nibble driven to the port |
| port_doe | output | 1 | Data pin output enable (1 = block drives) |
| port_din | input | 4 | Data nibble from the port (asynchronous) |
| port_sync | output | 1 | Sync strobe |
| port_mode | output | 1 | Mode select, held high for RAM-monitor mode |
| port_rst_n | output | 1 | Target reset, active low |

## Verification
Reads are swept over all four size codes, three divider settings (including 0) and zero to three busy status nibbles before the ready status. Each combination uses a distinct address and data pattern. The size sweep tells apart the command encoding, the nibble count and the zero-extension. The reserved code shows whether it folds to long word. The busy-nibble count shows whether polling keeps going until the exact value 4'b0001 and whether sync rises on that nibble only. Asymmetric data and address patterns show nibble and byte ordering errors. Holding the response before accepting it shows whether the output stays stable and new requests stay blocked.

// File: rtl/dbgport_pkg.sv
// Shared types and helpers for the debug-port RAM monitor read sequencer.
// Assumes a 4-bit data port and 32-bit addresses and data words.
package dbgport_pkg;

    localparam int NIB_W   = 4;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / NIB_W;
    localparam int LANE_IW = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_LEAD,
        ST_CMD,
        ST_ADDR,
        ST_POLL,
        ST_DATA,
        ST_RESP
    } seq_state_e;

    localparam logic [NIB_W-1:0] READY_CODE = 4'b0001;
    localparam logic [1:0]       READ_OP    = 2'b10;

    // Fold the reserved size code onto long word.
    function automatic acc_size_e norm_size(input logic [1:0] sz);
        return (sz == SZ_RSVD) ? SZ_LONG : acc_size_e'(sz);
    endfunction

    // Index of the last data nibble for an access size.
    function automatic logic [LANE_IW-1:0] last_lane(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return LANE_IW'(1);
            SZ_WORD: return LANE_IW'(3);
            default: return LANE_IW'(LANES - 1);
        endcase
    endfunction

endpackage

// File: rtl/dbgport_sync.sv
// Two-flop synchronizer for the asynchronous port data pins.
// Assumes the target holds each nibble for many system clocks.
module dbgport_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] meta_q;

    // Two register stages toward the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end

endmodule

// File: rtl/dbgport_phy.sv
// One-nibble port transfer engine.
// A start pulse launches one port clock pulse. The clock is low for the
// effective half period and then high for the same time. An output nibble
// is registered on the data pins when the low half begins. An input nibble
// is captured at the rising edge. done pulses for one cycle after the clock
// returns low. Assumes start arrives only while the engine is idle.
module dbgport_phy
    import dbgport_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             start,
    input  logic             dir_out,
    input  logic [NIB_W-1:0] nib_out,
    input  logic [NIB_W-1:0] din_s,
    output logic             port_clk,
    output logic [NIB_W-1:0] port_dout,
    output logic [NIB_W-1:0] nib_in,
    output logic             done
);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_state_e;

    ph_state_e        ph_q;
    logic [DIV_W-1:0] timer_q;
    logic [DIV_W-1:0] half_eff;
    logic             half_end;

    // Effective half period: zero is treated as one.
    always_comb begin
        half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
        half_end = (timer_q == half_eff - DIV_W'(1));
    end

    // Clock phase sequencing, data launch and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            timer_q   <= '0;
            port_clk  <= 1'b0;
            port_dout <= '0;
            nib_in    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        timer_q <= '0;
                        ph_q    <= PH_LOW;
                        if (dir_out) port_dout <= nib_out;
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        port_clk <= 1'b1;
                        nib_in   <= din_s;
                        timer_q  <= '0;
                        ph_q     <= PH_HIGH;
                    end else begin
                        timer_q <= timer_q + DIV_W'(1);
                    end
                end
                default: begin
                    if (half_end) begin
                        port_clk <= 1'b0;
                        done     <= 1'b1;
                        ph_q     <= PH_IDLE;
                    end else begin
                        timer_q <= timer_q + DIV_W'(1);
                    end
                end
            endcase
        end
    end

    // Checker counter: system clocks the port clock has been high.
    logic [DIV_W-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_run_q <= '0;
        else if (port_clk) hi_run_q <= hi_run_q + DIV_W'(1);
        else               hi_run_q <= '0;
    end

    AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !port_clk);                                       // R3
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_clk) |-> hi_run_q == half_eff);                 // R3

endmodule

// File: rtl/dbgport_pack.sv
// Response word assembler: writes one nibble lane per data nibble.
// Lane index 0 is bits 3:0. Clearing zeroes every lane so that bits above
// the access size read as zero.
module dbgport_pack
    import dbgport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr,
    input  logic [LANE_IW-1:0] idx,
    input  logic [NIB_W-1:0]   nib,
    output logic [WORD_W-1:0]  word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane register: cleared per request, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                word[g*NIB_W +: NIB_W] <= '0;
            else if (wr && idx == LANE_IW'(g))
                word[g*NIB_W +: NIB_W] <= nib;
        end
    end

endmodule

// File: rtl/dbgport_rdseq.sv
// Debug-port RAM monitor read sequencer (top).
// After reset it runs the target reset handshake. It then serves one read
// per request: sync low, lead-in, command, address nibbles, ready polling,
// data collection, and a response handed over on a valid/ready channel.
// Assumes half_div changes only while the block is idle and the target
// eventually answers with the ready status.
module dbgport_rdseq
    import dbgport_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int INIT_NIBS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic              port_clk,
    output logic [NIB_W-1:0]  port_dout,
    output logic              port_doe,
    input  logic [NIB_W-1:0]  port_din,
    output logic              port_sync,
    output logic              port_mode,
    output logic              port_rst_n
);

    localparam int INIT_TOTAL = 2 * INIT_NIBS;
    localparam int CNT_W      = $clog2(INIT_TOTAL + 1);
    localparam int ADDR_NIBS  = ADDR_W / NIB_W;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_sh_q;
    acc_size_e         size_q;
    logic              pend_q;
    logic              start_q;
    logic              xfer_st;
    logic              dir_out;
    logic              accept;
    logic [NIB_W-1:0]  nib_tx;
    logic [NIB_W-1:0]  din_s;
    logic [NIB_W-1:0]  nib_rx;
    logic              ph_done;
    logic              pack_wr;

    assign port_mode = 1'b1;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign pack_wr   = ph_done && (state_q == ST_DATA);

    // Transfer direction and outgoing nibble for the current state.
    always_comb begin
        xfer_st = (state_q != ST_IDLE) && (state_q != ST_RESP);
        dir_out = (state_q != ST_POLL) && (state_q != ST_DATA);
        case (state_q)
            ST_CMD:  nib_tx = {READ_OP, size_q};
            ST_ADDR: nib_tx = addr_sh_q[NIB_W-1:0];
            default: nib_tx = '0;
        endcase
    end

    // Main sequencer: issues transfers and steps through the read frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_INIT;
            cnt_q      <= '0;
            addr_sh_q  <= '0;
            size_q     <= SZ_BYTE;
            pend_q     <= 1'b0;
            start_q    <= 1'b0;
            port_doe   <= 1'b1;
            port_sync  <= 1'b1;
            port_rst_n <= 1'b0;
            rsp_valid  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (xfer_st && !pend_q) begin
                start_q <= 1'b1;
                pend_q  <= 1'b1;
            end
            if (ph_done) pend_q <= 1'b0;

            case (state_q)
                ST_INIT: begin
                    if (ph_done) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(INIT_NIBS - 1))
                            port_rst_n <= 1'b1;
                        if (cnt_q == CNT_W'(INIT_TOTAL - 1)) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (accept) begin
                        addr_sh_q <= req_addr;
                        size_q    <= norm_size(req_size);
                        port_sync <= 1'b0;
                        port_doe  <= 1'b1;
                        cnt_q     <= '0;
                        state_q   <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (ph_done) state_q <= ST_CMD;
                end
                ST_CMD: begin
                    if (ph_done) state_q <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (ph_done) begin
                        addr_sh_q <= addr_sh_q >> NIB_W;
                        cnt_q     <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
                            cnt_q    <= '0;
                            port_doe <= 1'b0;
                            state_q  <= ST_POLL;
                        end
                    end
                end
                ST_POLL: begin
                    if (ph_done && nib_rx == READY_CODE) begin
                        port_sync <= 1'b1;
                        state_q   <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (ph_done) begin
                        cnt_q     <= cnt_q + CNT_W'(1);
                        port_sync <= 1'b0;
                        if (cnt_q[LANE_IW-1:0] == last_lane(size_q)) begin
                            cnt_q     <= '0;
                            rsp_valid <= 1'b1;
                            state_q   <= ST_RESP;
                        end
                    end
                end
                default: begin
                    if (rsp_ready) begin
                        rsp_valid <= 1'b0;
                        state_q   <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    dbgport_sync #(.W(NIB_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (port_din),
        .d_sync  (din_s)
    );

    dbgport_phy #(.DIV_W(DIV_W)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .start     (start_q),
        .dir_out   (dir_out),
        .nib_out   (nib_tx),
        .din_s     (din_s),
        .port_clk  (port_clk),
        .port_dout (port_dout),
        .nib_in    (nib_rx),
        .done      (ph_done)
    );

    dbgport_pack u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .wr    (pack_wr),
        .idx   (cnt_q[LANE_IW-1:0]),
        .nib   (nib_rx),
        .word  (rsp_data)
    );

    AST_INIT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> (port_sync && port_doe && !req_ready));   // R2
    AST_INPUT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL || state_q == ST_DATA) |-> !port_doe);         // R6
    AST_DATA_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> cnt_q <= CNT_W'(last_lane(size_q)));      // R7
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));  // R9
    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid);                                         // R9

endmodule

// File: tb/dbgport_rdseq_bench.sv
// Bench: models the target side of the port and sweeps size, divider
// and busy-status count, checking framing, timing and the returned word.
module dbgport_rdseq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] half_div = 16'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        port_clk;
    logic [3:0]  port_dout;
    logic        port_doe;
    logic [3:0]  port_din = '0;
    logic        port_sync;
    logic        port_mode;
    logic        port_rst_n;

    always #2 clk = ~clk;   // 250 MHz

    dbgport_rdseq u_dbgport_rdseq (
        .clk (clk), .rst_n (rst_n), .half_div (half_div),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_size (req_size),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data),
        .port_clk (port_clk), .port_dout (port_dout), .port_doe (port_doe),
        .port_din (port_din), .port_sync (port_sync), .port_mode (port_mode),
        .port_rst_n (port_rst_n)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Target model state
    int         phase = 0;          // 0: init handshake, 1: reads
    int         rst_lo = 0, rst_hi = 0;
    logic [3:0] resp [32];
    int         in_cnt = 0;
    int         cur_waits = 0;
    logic [3:0] out_log [16];
    int         out_n = 0;
    int         hi_cnt = 0;
    int         exp_half = 2;

    // Port clock rising edge: record and check what the block presents.
    always @(posedge port_clk) begin
        chk(port_mode == 1'b1, "R1", "mode pin", 32'(port_mode), 32'h1);
        if (phase == 0) begin
            chk(port_doe && port_sync && port_dout == 4'h0, "R2",
                "init pins {doe,sync,dout}",
                {26'h0, port_doe, port_sync, port_dout}, 32'h30);
            if (!port_rst_n) rst_lo++; else rst_hi++;
        end else if (port_doe) begin
            if (out_n < 16) out_log[out_n] = port_dout;
            out_n++;
            in_cnt = 0;
            chk(!port_sync, "R4", "sync during command", 32'(port_sync), 32'h0);
        end else begin
            chk(port_sync == (in_cnt == cur_waits + 1), "R7",
                "sync at input nibble", 32'(port_sync),
                32'(in_cnt == cur_waits + 1));
            in_cnt++;
        end
    end

    // Port clock falling edge: check high width, present next nibble.
    always @(negedge port_clk) begin
        chk(hi_cnt == exp_half, "R3", "clock high width", 32'(hi_cnt),
            32'(exp_half));
        hi_cnt = 0;
        port_din = (in_cnt < 32) ? resp[in_cnt] : 4'h0;
    end

    always @(negedge clk) if (port_clk) hi_cnt++;

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            chk(1'b0, "R9", "watchdog hang", 32'(cycles), 32'h0);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic do_read(input logic [31:0] addr, input logic [1:0] sz,
                           input int waits, input logic [31:0] data,
                           input logic [15:0] div, input int hold);
        int nb;
        logic [1:0]  sze;
        logic [31:0] expw;
        sze  = (sz == 2'b11) ? 2'b10 : sz;
        nb   = (sze == 2'b00) ? 1 : (sze == 2'b01) ? 2 : 4;
        expw = (nb == 4) ? data : (data & ((32'h1 << (8 * nb)) - 1));
        @(negedge clk);
        half_div  = div;
        exp_half  = (div == 0) ? 1 : int'(div);
        cur_waits = waits;
        for (int k = 0; k < 32; k++) resp[k] = 4'h0;
        for (int k = 0; k < waits; k++) resp[k] = 4'((k % 4) * 4);
        resp[waits] = 4'b0001;
        for (int k = 0; k < 2 * nb; k++) resp[waits + 1 + k] = data[4*k +: 4];
        out_n = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9", "busy after accept", 32'(req_ready), 32'h0);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_data == expw, "R8", "read word", rsp_data, expw);
        chk(!req_ready, "R9", "no request while response pending",
            32'(req_ready), 32'h0);
        for (int h = 0; h < hold; h++) @(negedge clk);
        chk(rsp_valid && rsp_data == expw, "R9", "response held",
            rsp_data, expw);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9", "idle after take",
            {30'h0, rsp_valid, req_ready}, 32'h1);
        chk(out_n == 10, "R5", "output nibble count", 32'(out_n), 32'd10);
        chk(out_log[0] == 4'h0, "R4", "lead-in nibble", 32'(out_log[0]), 32'h0);
        chk(out_log[1] == {2'b10, sze}, "R4", "command nibble",
            32'(out_log[1]), 32'({2'b10, sze}));
        for (int k = 0; k < 8; k++)
            chk(out_log[2 + k] == addr[4*k +: 4], "R5", "address nibble",
                32'(out_log[2 + k]), 32'(addr[4*k +: 4]));
        chk(in_cnt == waits + 1 + 2 * nb, "R6", "input nibble count",
            32'(in_cnt), 32'(waits + 1 + 2 * nb));
    endtask

    initial begin
        for (int k = 0; k < 32; k++) resp[k] = 4'h0;
        repeat (4) @(negedge clk);
        chk(!req_ready && !rsp_valid && !port_clk && !port_rst_n, "R2",
            "reset state {ready,valid,clk,rst_n}",
            {28'h0, req_ready, rsp_valid, port_clk, port_rst_n}, 32'h0);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk(rst_lo == 10, "R2", "nibbles in target reset", 32'(rst_lo), 32'd10);
        chk(rst_hi == 10, "R2", "nibbles after release", 32'(rst_hi), 32'd10);
        chk(port_rst_n, "R2", "reset released", 32'(port_rst_n), 32'h1);
        phase = 1;
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 3; d++)
                for (int w = 0; w < 4; w++) begin
                    int idx;
                    idx = s * 12 + d * 4 + w;
                    do_read(32'h1357_9BDF ^ (32'(idx) * 32'h0F1E_2D3C),
                            2'(s), w,
                            32'hA5C3_96E1 + 32'(idx) * 32'h1213_1415,
                            (d == 0) ? 16'd0 : (d == 1) ? 16'd1 : 16'd3,
                            idx % 3);
                end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule